// File: doc/BRIEF.md
# SIMD Power Domain Sequencer

This block orders the hardware handshake that takes a separately supplied SIMD coprocessor domain out of power and brings it back. It drives four controls: the domain's reset, the enable of the clamps on the domain's outputs, the enable of the domain's power switch, and, for sequences run with the main core held in reset, the core reset. The sequence to run is chosen by a one-cycle request pulse, either up or down. A mode flag, sampled with the request, selects between a variant that runs while the core keeps executing and a variant that holds the core in reset for the whole sequence.

On the way down, the domain reset goes low first and stays low for a set number of cycles. Then the clamps close, and only then is power cut. On the way up, power is applied first. The block waits for the switch's power-good acknowledge before it takes any further step. In the running variant it then releases the domain reset and waits a settling interval before it opens the clamps. In the in-reset variant the clamps open while both resets are still held, and both resets are released on the following cycle. Every output comes from a register. A request that would break the ordering is refused, and a protocol-error flag is raised.

Top module: `simd_pwr_seq`

## Requirements
- R1: After power-on reset the outputs show the off state: domain reset asserted (dom_rst_n=0), clamp active (clamp_en=1), power disabled (pwr_en=0), core released (core_rst_n=1), and busy, done and err all low.
- R2: Power-down from the on state asserts the domain reset for exactly RST_HOLD_CYC (default 8) cycles with the clamp open. The clamp then closes for one cycle with power still on, and power is cut on the next cycle.
- R3: In the in-reset power-down variant (in_reset_mode=1 at the request), core_rst_n goes low together with dom_rst_n. It is released one cycle after pwr_en falls, while dom_rst_n stays low.
- R4: Running power-up (in_reset_mode=0) raises pwr_en on the cycle after the request. dom_rst_n is released on the cycle after pwr_good is sampled high. The clamp opens exactly SETTLE_CYC (default 20) cycles after dom_rst_n is released.
- R5: In-reset power-up first asserts core_rst_n for one cycle with power still off, then raises pwr_en. The clamp opens on the cycle after pwr_good is sampled high. Both resets are released on the next cycle.
- R6: Whenever pwr_en is low, dom_rst_n is low and clamp_en is high.
- R7: If pwr_good has not been seen PG_TIMEOUT_CYC (default 64) cycles after pwr_en rose, the block returns to the off state. It raises err and does not pulse done.
- R8: A power-up request is accepted only in the off state and a power-down request only in the on state. A redundant request (up while on, down while off) is ignored and leaves err low. A request during a sequence, or both requests in the same cycle, is ignored and sets err.
- R9: err stays set until the next accepted request clears it. done pulses high for exactly one cycle when a sequence completes.
- R10: busy is high from the cycle after an accepted request until the cycle on which the block settles in the off or on state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| req_up | input | 1 | Power-up request pulse |
| req_down | input | 1 | Power-down request pulse |
| in_reset_mode | input | 1 | 1 selects the variant that holds the core in reset; sampled with the request |
| pwr_good | input | 1 | Acknowledge from the power switch that the domain supply is valid |
| core_rst_n | output | 1 | Active-low main core reset |
| dom_rst_n | output | 1 | Active-low SIMD domain reset |
| clamp_en | output | 1 | High closes the domain's output clamps |
| pwr_en | output | 1 | High enables the domain power switch |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse when a sequence completes |
| err | output | 1 | Sticky protocol-error flag |

## Verification
Each control is a register decoded from the next sequence state, so a wrong state becomes visible on the pins on the very edge it is entered. A step that comes early or late shifts one of the four controls by at least one cycle against the per-cycle reference. A hold or settle counter that is off by one changes the length of the low-reset window or of the released-reset window before the clamp opens, and the bench measures both at the pins. A stale variant flag or a lost error update shows up as a core_rst_n level or an err value that differs on the following cycle.

// File: rtl/spd_pkg.sv
package spd_pkg;

  typedef enum logic [3:0] {
    ST_OFF,
    ST_ON,
    ST_DN_HOLD,
    ST_DN_CLAMP,
    ST_DN_CUT,
    ST_UP_CORE,
    ST_UP_WAIT,
    ST_UP_SETTLE,
    ST_UP_UNCLAMP
  } spd_state_e;

  typedef struct packed {
    logic core_rel;
    logic dom_rel;
    logic clamp;
    logic pwr;
  } spd_drive_t;

  function automatic int unsigned spd_cnt_bits(input int unsigned span);
    return (span < 2) ? 1 : $clog2(span);
  endfunction

  function automatic int unsigned spd_max(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic spd_is_idle(input spd_state_e s);
    return (s == ST_OFF) || (s == ST_ON);
  endfunction

  // Pin levels for each step; core_held selects the variant that keeps the core in reset.
  function automatic spd_drive_t spd_drive_of(input spd_state_e s, input logic core_held);
    spd_drive_t d;
    d = '{core_rel: 1'b1, dom_rel: 1'b0, clamp: 1'b1, pwr: 1'b0};
    case (s)
      ST_ON:         d = '{core_rel: 1'b1,       dom_rel: 1'b1, clamp: 1'b0, pwr: 1'b1};
      ST_DN_HOLD:    d = '{core_rel: !core_held, dom_rel: 1'b0, clamp: 1'b0, pwr: 1'b1};
      ST_DN_CLAMP:   d = '{core_rel: !core_held, dom_rel: 1'b0, clamp: 1'b1, pwr: 1'b1};
      ST_DN_CUT:     d = '{core_rel: !core_held, dom_rel: 1'b0, clamp: 1'b1, pwr: 1'b0};
      ST_UP_CORE:    d = '{core_rel: 1'b0,       dom_rel: 1'b0, clamp: 1'b1, pwr: 1'b0};
      ST_UP_WAIT:    d = '{core_rel: !core_held, dom_rel: 1'b0, clamp: 1'b1, pwr: 1'b1};
      ST_UP_SETTLE:  d = '{core_rel: 1'b1,       dom_rel: 1'b1, clamp: 1'b1, pwr: 1'b1};
      ST_UP_UNCLAMP: d = '{core_rel: 1'b0,       dom_rel: 1'b0, clamp: 1'b0, pwr: 1'b1};
      default:       d = '{core_rel: 1'b1,       dom_rel: 1'b0, clamp: 1'b1, pwr: 1'b0};
    endcase
    return d;
  endfunction

endpackage

// File: rtl/spd_countdown.sv
module spd_countdown #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         zero
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (dec && (cnt_q != '0)) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/spd_req_gate.sv
module spd_req_gate
  import spd_pkg::*;
(
  input  logic       req_up,
  input  logic       req_down,
  input  spd_state_e st_q,
  output logic       acc_up,
  output logic       acc_dn,
  output logic       proto_err
);

  logic both_req;
  logic any_req;
  logic seq_running;

  assign both_req    = req_up && req_down;
  assign any_req     = req_up || req_down;
  assign seq_running = !spd_is_idle(st_q);

  assign acc_up    = req_up   && !req_down && (st_q == ST_OFF);
  assign acc_dn    = req_down && !req_up   && (st_q == ST_ON);
  assign proto_err = both_req || (any_req && seq_running);

endmodule

// File: rtl/spd_fsm.sv
module spd_fsm
  import spd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       acc_up,
  input  logic       acc_dn,
  input  logic       mode_in,
  input  logic       pwr_good,
  input  logic       seq_zero,
  input  logic       pg_zero,
  output spd_state_e st_q,
  output spd_state_e st_d,
  output logic       held_d,
  output logic       seq_ld_hold,
  output logic       seq_ld_settle,
  output logic       seq_dec,
  output logic       pg_load,
  output logic       pg_dec,
  output logic       timeout_evt,
  output logic       finish_evt
);

  logic held_q;

  assign held_d = (acc_up || acc_dn) ? mode_in : held_q;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_OFF:        if (acc_up) st_d = mode_in ? ST_UP_CORE : ST_UP_WAIT;
      ST_ON:         if (acc_dn) st_d = ST_DN_HOLD;
      ST_DN_HOLD:    if (seq_zero) st_d = ST_DN_CLAMP;
      ST_DN_CLAMP:   st_d = ST_DN_CUT;
      ST_DN_CUT:     st_d = ST_OFF;
      ST_UP_CORE:    st_d = ST_UP_WAIT;
      ST_UP_WAIT: begin
        if (pwr_good)     st_d = held_q ? ST_UP_UNCLAMP : ST_UP_SETTLE;
        else if (pg_zero) st_d = ST_OFF;
      end
      ST_UP_SETTLE:  if (seq_zero) st_d = ST_ON;
      ST_UP_UNCLAMP: st_d = ST_ON;
      default:       st_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_OFF;
      held_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      held_q <= held_d;
    end
  end

  assign seq_ld_hold   = acc_dn;
  assign seq_ld_settle = (st_q == ST_UP_WAIT) && pwr_good && !held_q;
  assign seq_dec       = (st_q == ST_DN_HOLD) || (st_q == ST_UP_SETTLE);
  assign pg_load       = (st_d == ST_UP_WAIT) && (st_q != ST_UP_WAIT);
  assign pg_dec        = (st_q == ST_UP_WAIT);
  assign timeout_evt   = (st_q == ST_UP_WAIT) && !pwr_good && pg_zero;
  assign finish_evt    = !spd_is_idle(st_q) && spd_is_idle(st_d) && !timeout_evt;

  // A missing acknowledge ends the wait in the off state.
  assert_timeout_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_evt |=> (st_q == ST_OFF));

  // Requests are accepted only from a settled state.
  assert_accept_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_up || acc_dn) |=> !spd_is_idle(st_q));

endmodule

// File: rtl/simd_pwr_seq.sv
module simd_pwr_seq
  import spd_pkg::*;
#(
  parameter int unsigned RST_HOLD_CYC   = 8,
  parameter int unsigned SETTLE_CYC     = 20,
  parameter int unsigned PG_TIMEOUT_CYC = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_up,
  input  logic req_down,
  input  logic in_reset_mode,
  input  logic pwr_good,
  output logic core_rst_n,
  output logic dom_rst_n,
  output logic clamp_en,
  output logic pwr_en,
  output logic busy,
  output logic done,
  output logic err
);

  localparam int unsigned SEQ_SPAN = spd_max(RST_HOLD_CYC, SETTLE_CYC);
  localparam int unsigned SEQ_W    = spd_cnt_bits(SEQ_SPAN);
  localparam int unsigned PG_W     = spd_cnt_bits(PG_TIMEOUT_CYC);
  localparam logic [SEQ_W-1:0] HOLD_LD   = SEQ_W'(RST_HOLD_CYC - 1);
  localparam logic [SEQ_W-1:0] SETTLE_LD = SEQ_W'(SETTLE_CYC - 1);
  localparam logic [PG_W-1:0]  PG_LD     = PG_W'(PG_TIMEOUT_CYC - 1);
  localparam int unsigned MON_W = 16;
  localparam spd_drive_t OFF_DRIVE = '{core_rel: 1'b1, dom_rel: 1'b0, clamp: 1'b1, pwr: 1'b0};

  spd_state_e st_q, st_d;
  logic acc_up, acc_dn, proto_err;
  logic held_d;
  logic seq_ld_hold, seq_ld_settle, seq_dec, seq_zero;
  logic pg_load, pg_dec, pg_zero;
  logic timeout_evt, finish_evt;
  logic seq_load;
  logic [SEQ_W-1:0] seq_val;

  spd_req_gate u_gate (
    .req_up    (req_up),
    .req_down  (req_down),
    .st_q      (st_q),
    .acc_up    (acc_up),
    .acc_dn    (acc_dn),
    .proto_err (proto_err)
  );

  spd_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .acc_up        (acc_up),
    .acc_dn        (acc_dn),
    .mode_in       (in_reset_mode),
    .pwr_good      (pwr_good),
    .seq_zero      (seq_zero),
    .pg_zero       (pg_zero),
    .st_q          (st_q),
    .st_d          (st_d),
    .held_d        (held_d),
    .seq_ld_hold   (seq_ld_hold),
    .seq_ld_settle (seq_ld_settle),
    .seq_dec       (seq_dec),
    .pg_load       (pg_load),
    .pg_dec        (pg_dec),
    .timeout_evt   (timeout_evt),
    .finish_evt    (finish_evt)
  );

  assign seq_load = seq_ld_hold || seq_ld_settle;
  assign seq_val  = seq_ld_hold ? HOLD_LD : SETTLE_LD;

  spd_countdown #(.W(SEQ_W)) u_seq_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (seq_load),
    .load_val (seq_val),
    .dec      (seq_dec),
    .zero     (seq_zero)
  );

  spd_countdown #(.W(PG_W)) u_pg_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (pg_load),
    .load_val (PG_LD),
    .dec      (pg_dec),
    .zero     (pg_zero)
  );

  spd_drive_t drive_q;
  logic busy_q, done_q, err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drive_q <= OFF_DRIVE;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      drive_q <= spd_drive_of(st_d, held_d);
      busy_q  <= !spd_is_idle(st_d);
      done_q  <= finish_evt;
      if (acc_up || acc_dn)             err_q <= 1'b0;
      else if (proto_err || timeout_evt) err_q <= 1'b1;
    end
  end

  assign core_rst_n = drive_q.core_rel;
  assign dom_rst_n  = drive_q.dom_rel;
  assign clamp_en   = drive_q.clamp;
  assign pwr_en     = drive_q.pwr;
  assign busy       = busy_q;
  assign done       = done_q;
  assign err        = err_q;

  // Pin-level run-length monitors feeding the ordering checks.
  logic [MON_W-1:0] hold_run, rel_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_run <= '0;
      rel_run  <= '0;
    end else begin
      if (dom_rst_n)             hold_run <= '0;
      else if (hold_run != '1)   hold_run <= hold_run + 1'b1;
      if (!dom_rst_n)            rel_run  <= '0;
      else if (rel_run != '1)    rel_run  <= rel_run + 1'b1;
    end
  end

  assert_unpowered_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_en |-> !dom_rst_n);

  assert_unpowered_clamp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_en |-> clamp_en);

  assert_hold_before_clamp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clamp_en) |-> (32'(hold_run) >= RST_HOLD_CYC));

  assert_clamp_before_cut_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_en) |-> $past(clamp_en));

  assert_settle_before_unclamp_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clamp_en) |-> (!dom_rst_n || (32'(rel_run) >= SETTLE_CYC)));

  assert_core_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(core_rst_n) && !dom_rst_n) |-> !pwr_en);

  assert_busy_request_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (req_up || req_down)) |=> err);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

endmodule

// File: tb/test_simd_pwr_seq.sv
module test_simd_pwr_seq;

  localparam int HOLD   = 8;
  localparam int SETTLE = 20;
  localparam int TMO    = 64;

  localparam int M_OFF  = 0;
  localparam int M_ON   = 1;
  localparam int M_RUN  = 2;
  localparam int M_WAIT = 3;
  localparam int T_OFF  = 0;
  localparam int T_ON   = 1;
  localparam int T_WAIT = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_up = 1'b0, req_down = 1'b0, in_reset_mode = 1'b0, pwr_good = 1'b0;
  logic core_rst_n, dom_rst_n, clamp_en, pwr_en, busy, done, err;

  always #4 clk = ~clk;

  simd_pwr_seq #(
    .RST_HOLD_CYC   (HOLD),
    .SETTLE_CYC     (SETTLE),
    .PG_TIMEOUT_CYC (TMO)
  ) i_simd_pwr_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_up        (req_up),
    .req_down      (req_down),
    .in_reset_mode (in_reset_mode),
    .pwr_good      (pwr_good),
    .core_rst_n    (core_rst_n),
    .dom_rst_n     (dom_rst_n),
    .clamp_en      (clamp_en),
    .pwr_en        (pwr_en),
    .busy          (busy),
    .done          (done),
    .err           (err)
  );

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;
  string tag = "R1";

  // Switch model: acknowledge pg_delay cycles after enable.
  bit pg_on = 1;
  int pg_delay = 3;
  int pg_cnt = 0;
  always @(negedge clk) begin
    #1;
    if (pg_on && pwr_en) begin
      pg_cnt++;
      pwr_good = (pg_cnt >= pg_delay);
    end else begin
      pg_cnt = 0;
      pwr_good = 1'b0;
    end
  end

  // Reference model: expected {core,dom,clamp,pwr} plus busy/done/err.
  logic [3:0] sched[$];
  logic [3:0] m_cur = 4'b1010;
  int m_mode = M_OFF, m_tail = T_OFF, m_wait = 0;
  logic m_rst = 1'b0;
  logic e_busy = 1'b0, e_done = 1'b0, e_err = 1'b0;

  always @(posedge clk) begin
    logic anyreq;
    logic [3:0] v;
    if (!rst_n) begin
      sched.delete();
      m_cur = 4'b1010; m_mode = M_OFF; e_err = 1'b0; e_done = 1'b0;
    end else begin
      e_done = 1'b0;
      anyreq = req_up || req_down;
      if (m_mode == M_OFF || m_mode == M_ON) begin
        if (req_up && req_down) e_err = 1'b1;
        else if (req_up && m_mode == M_OFF) begin
          e_err = 1'b0; m_rst = in_reset_mode;
          if (m_rst) begin m_cur = 4'b0010; m_tail = T_WAIT; m_mode = M_RUN; end
          else begin m_cur = 4'b1011; m_mode = M_WAIT; m_wait = 0; end
        end else if (req_down && m_mode == M_ON) begin
          e_err = 1'b0; m_rst = in_reset_mode;
          v = {~m_rst, 3'b001};
          m_cur = v;
          for (int i = 0; i < HOLD - 1; i++) sched.push_back(v);
          sched.push_back({~m_rst, 3'b011});
          sched.push_back({~m_rst, 3'b010});
          m_tail = T_OFF; m_mode = M_RUN;
        end
      end else if (m_mode == M_RUN) begin
        if (anyreq) e_err = 1'b1;
        if (sched.size() > 0) m_cur = sched.pop_front();
        else if (m_tail == T_OFF) begin m_cur = 4'b1010; e_done = 1'b1; m_mode = M_OFF; end
        else if (m_tail == T_ON) begin m_cur = 4'b1101; e_done = 1'b1; m_mode = M_ON; end
        else begin m_cur = {~m_rst, 3'b011}; m_mode = M_WAIT; m_wait = 0; end
      end else begin
        if (anyreq) e_err = 1'b1;
        if (pwr_good) begin
          if (m_rst) m_cur = 4'b0001;
          else begin
            m_cur = 4'b1111;
            for (int i = 0; i < SETTLE - 1; i++) sched.push_back(4'b1111);
          end
          m_tail = T_ON; m_mode = M_RUN;
        end else if (m_wait == TMO - 1) begin
          m_cur = 4'b1010; e_err = 1'b1; m_mode = M_OFF;
        end else m_wait++;
      end
    end
    e_busy = (m_mode == M_RUN) || (m_mode == M_WAIT);
  end

  // Per-cycle comparison away from the active edge.
  always @(negedge clk) begin
    logic [6:0] act, exp_v;
    if (rst_n && !finished) begin
      act   = {core_rst_n, dom_rst_n, clamp_en, pwr_en, busy, done, err};
      exp_v = {m_cur, e_busy, e_done, e_err};
      compared++;
      if (act !== exp_v) begin
        mismatched++;
        $display("FAIL %s t=%0t core/dom/clamp/pwr/busy/done/err got %b expected %b", tag, $time, act, exp_v);
      end
      // R6 invariant checked directly at the pins
      compared++;
      if (!pwr_en && (dom_rst_n || !clamp_en)) begin
        mismatched++;
        $display("FAIL R6 t=%0t dom_rst_n=%b clamp_en=%b with pwr_en low, expected 0/1", $time, dom_rst_n, clamp_en);
      end
    end
  end

  task automatic send(input logic u, input logic d, input logic m);
    @(negedge clk); #1;
    req_up = u; req_down = d; in_reset_mode = m;
    @(negedge clk); #1;
    req_up = 1'b0; req_down = 1'b0;
  endtask

  task automatic settle_idle();
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if ((m_mode == M_OFF || m_mode == M_ON) && sched.size() == 0) break;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired in %s", tag);
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    tag = "R1";
    compared++;
    if ({core_rst_n, dom_rst_n, clamp_en, pwr_en, busy, done, err} !== 7'b1010000) begin
      mismatched++;
      $display("FAIL R1 reset state got %b expected %b",
               {core_rst_n, dom_rst_n, clamp_en, pwr_en, busy, done, err}, 7'b1010000);
    end
    // R4 running power-up, R10 busy window, R9 done pulse
    tag = "R4"; pg_delay = 5;
    send(1, 0, 0); settle_idle();
    // R8 redundant up while on: ignored without error
    tag = "R8"; send(1, 0, 0); settle_idle();
    // R2 running power-down ordering
    tag = "R2"; send(0, 1, 0); settle_idle();
    // R8 redundant down while off
    tag = "R8"; send(0, 1, 1); settle_idle();
    // R5 in-reset power-up
    tag = "R5"; pg_delay = 2; send(1, 0, 1); settle_idle();
    // R3 in-reset power-down
    tag = "R3"; send(0, 1, 1); settle_idle();
    // R7 acknowledge never arrives
    tag = "R7"; pg_on = 0; send(1, 0, 0); settle_idle(); pg_on = 1;
    // R9 sticky err cleared by an accepted request
    tag = "R9"; pg_delay = 1; send(1, 0, 1); settle_idle();
    // R8 request in the middle of a sequence
    tag = "R8"; send(0, 1, 0);
    repeat (3) @(negedge clk);
    send(1, 0, 0); settle_idle();
    // R8 simultaneous requests in the off state
    tag = "R8"; send(1, 1, 0); settle_idle();
    // R10 busy through a full running power-up with slow acknowledge
    tag = "R10"; pg_delay = 9; send(1, 0, 0); settle_idle();
    finish_run();
  end

endmodule